// File: doc/BRIEF.md
# Run-Length Configuration Bit Expander

This block turns a compressed configuration byte stream into the serial bit stream that a configuration shifter loads into a programmable device. Bytes enter on a valid/ready interface with an end-of-stream flag. Single bits leave on a one-bit valid/ready interface.

The block first skips leading header bytes until it sees a two-byte start marker. It then sends a fixed 16-bit prefix. After that, it treats every byte as a run-length code and expands it into a run of identical bits, with an optional single closing bit of the opposite value. At the end of a stream it goes back to hunting for the next marker. If a stream ends before any marker is seen, it raises a flag.

Top module: `rle_bit_expander`

## Requirements
- R1: While reset is held and in the cycle after it is released, `in_ready` is 1, `out_valid` is 0 and `marker_missing` is 0.
- R2: The start marker is a byte 0xFF followed directly by a byte whose bits [7:4] equal 4'b0011. A run of several 0xFF bytes before that second byte still forms the marker. Bytes before the marker and both marker bytes produce no output bits.
- R3: Once the marker is complete, the block sends the 16-bit value 0xFF20, bit 15 first, before any expanded bit. If the second marker byte carries `in_last`, only the prefix is sent.
- R4: A code byte n with 1 <= n <= 226 yields n one-bits followed by one zero-bit.
- R5: Code byte 227 yields 226 one-bits and no closing zero.
- R6: A code byte n with 228 <= n <= 254 yields (n - 228) zero-bits followed by one one-bit, so code 228 yields a single one.
- R7: Code byte 255 yields a single one-bit, and code byte 0 yields no bits.
- R8: `in_ready` is never 1 while `out_valid` is 1, so a new byte is taken only after every bit of the prefix and of the current code has been handed off.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_bit` holds its value on the next cycle.
- R10: If a byte carrying `in_last` is accepted before the marker is complete, `marker_missing` goes to 1 and no bits are emitted. The flag stays at 1 until a later marker completes, which clears it.
- R11: A code byte carrying `in_last` ends the stream. The bytes after it are searched for a new marker and are not expanded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte (header, marker or run-length code) |
| in_last | input | 1 | Marks the final byte of a stream |
| in_ready | output | 1 | Block accepts a byte this cycle |
| out_valid | output | 1 | Output bit valid |
| out_bit | output | 1 | Serial output bit |
| out_ready | input | 1 | Downstream shifter takes the bit |
| marker_missing | output | 1 | A stream ended with no start marker |

## Verification
A wrong hunting state shows up as a missing or extra 16-bit prefix. It can also show up as header bytes being expanded as codes, which adds dozens of stray bits before the first expected one. A wrong prefix index or run counter changes the bit sequence or its length. That difference is visible at `out_bit` within the same code's expansion, at most 227 handshakes after the byte is taken. A fault in the busy gating shows `in_ready` and `out_valid` high together in the first cycle it occurs. A fault in the flag logic is seen the cycle after the closing byte of a stream with no marker.

// File: rtl/rle_exp_pkg.sv
package rle_exp_pkg;

    localparam int CODE_W = 8;

    typedef enum logic [1:0] {
        ST_HUNT,
        ST_HUNT_FF,
        ST_PREFIX,
        ST_CODE
    } scan_st_e;

    // One code byte reduced to a run and an optional closing bit.
    typedef struct packed {
        logic              lead_bit;
        logic [CODE_W-1:0] lead_cnt;
        logic              tail_en;
        logic              tail_bit;
    } run_desc_t;

endpackage

// File: rtl/rle_code_decode.sv
module rle_code_decode
    import rle_exp_pkg::*;
#(
    parameter int MAX_RUN = 226
) (
    input  logic [CODE_W-1:0] code,
    output run_desc_t         desc
);
    localparam logic [CODE_W-1:0] MAX_C    = CODE_W'(MAX_RUN);
    localparam logic [CODE_W-1:0] FULL_C   = CODE_W'(MAX_RUN + 1);
    localparam logic [CODE_W-1:0] ZBASE_C  = CODE_W'(MAX_RUN + 2);
    localparam logic [CODE_W-1:0] SINGLE_C = {CODE_W{1'b1}};

    always_comb begin
        desc = '0;
        if (code == '0) begin
            desc = '0;
        end else if (code <= MAX_C) begin
            desc.lead_bit = 1'b1;
            desc.lead_cnt = code;
            desc.tail_en  = 1'b1;
            desc.tail_bit = 1'b0;
        end else if (code == FULL_C) begin
            desc.lead_bit = 1'b1;
            desc.lead_cnt = MAX_C;
            desc.tail_en  = 1'b0;
        end else if (code == SINGLE_C) begin
            desc.lead_cnt = '0;
            desc.tail_en  = 1'b1;
            desc.tail_bit = 1'b1;
        end else begin
            desc.lead_bit = 1'b0;
            desc.lead_cnt = code - ZBASE_C;
            desc.tail_en  = 1'b1;
            desc.tail_bit = 1'b1;
        end
    end

endmodule

// File: rtl/rle_bit_emitter.sv
module rle_bit_emitter
    import rle_exp_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      load,
    input  run_desc_t desc,
    input  logic      out_ready,
    output logic      out_valid,
    output logic      out_bit
);
    typedef struct packed {
        logic              lead_bit;
        logic [CODE_W-1:0] cnt;
        logic              tail_pend;
        logic              tail_bit;
    } emit_state_t;

    emit_state_t emit_q, emit_d;

    logic run_left;

    always_comb begin
        run_left  = (emit_q.cnt != '0);
        out_valid = run_left || emit_q.tail_pend;
        out_bit   = run_left ? emit_q.lead_bit : emit_q.tail_bit;

        emit_d = emit_q;
        if (load) begin
            emit_d.lead_bit  = desc.lead_bit;
            emit_d.cnt       = desc.lead_cnt;
            emit_d.tail_pend = desc.tail_en;
            emit_d.tail_bit  = desc.tail_bit;
        end else if (out_valid && out_ready) begin
            if (run_left) begin
                emit_d.cnt = emit_q.cnt - 1'b1;
            end else begin
                emit_d.tail_pend = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            emit_q <= '0;
        end else begin
            emit_q <= emit_d;
        end
    end

endmodule

// File: rtl/rle_bit_expander.sv
module rle_bit_expander
    import rle_exp_pkg::*;
#(
    parameter int              MAX_RUN    = 226,
    parameter int              PREFIX_W   = 16,
    parameter logic [15:0]     PREFIX_VAL = 16'hFF20,
    parameter logic [7:0]      MARK_HEAD  = 8'hFF,
    parameter logic [3:0]      MARK_NIB   = 4'h3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    input  logic       in_last,
    output logic       in_ready,
    output logic       out_valid,
    output logic       out_bit,
    input  logic       out_ready,
    output logic       marker_missing
);
    localparam int PIDX_W = (PREFIX_W > 1) ? $clog2(PREFIX_W) : 1;
    localparam logic [PIDX_W-1:0] PIDX_TOP = PIDX_W'(PREFIX_W - 1);

    typedef struct packed {
        scan_st_e          st;
        logic [PIDX_W-1:0] pidx;
        logic              pfx_last;
        logic              missing;
    } top_state_t;

    top_state_t ctl_q, ctl_d;

    run_desc_t code_desc;
    logic      emit_load;
    logic      emit_valid;
    logic      emit_bit;
    logic      accept;
    logic      is_head;
    logic      is_second;

    rle_code_decode #(
        .MAX_RUN (MAX_RUN)
    ) u_decode (
        .code (in_data),
        .desc (code_desc)
    );

    rle_bit_emitter u_emit (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (emit_load),
        .desc      (code_desc),
        .out_ready (out_ready),
        .out_valid (emit_valid),
        .out_bit   (emit_bit)
    );

    always_comb begin
        ctl_d     = ctl_q;
        emit_load = 1'b0;
        in_ready  = (ctl_q.st != ST_PREFIX) && !emit_valid;
        accept    = in_valid && in_ready;
        is_head   = (in_data == MARK_HEAD);
        is_second = (in_data[7:4] == MARK_NIB);

        unique case (ctl_q.st)
            ST_HUNT: begin
                if (accept) begin
                    if (in_last) begin
                        ctl_d.missing = 1'b1;
                    end else if (is_head) begin
                        ctl_d.st = ST_HUNT_FF;
                    end
                end
            end
            ST_HUNT_FF: begin
                if (accept) begin
                    if (is_second) begin
                        ctl_d.st       = ST_PREFIX;
                        ctl_d.pidx     = PIDX_TOP;
                        ctl_d.pfx_last = in_last;
                        ctl_d.missing  = 1'b0;
                    end else if (in_last) begin
                        ctl_d.st      = ST_HUNT;
                        ctl_d.missing = 1'b1;
                    end else if (!is_head) begin
                        ctl_d.st = ST_HUNT;
                    end
                end
            end
            ST_PREFIX: begin
                if (out_ready) begin
                    if (ctl_q.pidx == '0) begin
                        ctl_d.st = ctl_q.pfx_last ? ST_HUNT : ST_CODE;
                    end else begin
                        ctl_d.pidx = ctl_q.pidx - 1'b1;
                    end
                end
            end
            ST_CODE: begin
                if (accept) begin
                    emit_load = 1'b1;
                    if (in_last) begin
                        ctl_d.st = ST_HUNT;
                    end
                end
            end
            default: ctl_d.st = ST_HUNT;
        endcase

        out_valid      = (ctl_q.st == ST_PREFIX) || emit_valid;
        out_bit        = (ctl_q.st == ST_PREFIX) ? PREFIX_VAL[ctl_q.pidx] : emit_bit;
        marker_missing = ctl_q.missing;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.st       <= ST_HUNT;
            ctl_q.pidx     <= '0;
            ctl_q.pfx_last <= 1'b0;
            ctl_q.missing  <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

endmodule

// File: rtl/rle_bit_expander_chk.sv
module rle_bit_expander_chk (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic in_last,
    input logic in_ready,
    input logic out_valid,
    input logic out_bit,
    input logic out_ready,
    input logic marker_missing
);
    // R8: no byte is taken while a bit is still pending
    p_no_overlap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid));

    // R9: a stalled bit stays offered
    p_valid_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> out_valid);

    // R9: a stalled bit keeps its value
    p_bit_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> $stable(out_bit));

    // R10: the flag is raised only by an accepted closing byte
    p_flag_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(marker_missing) |-> $past(in_valid && in_ready && in_last));

    // R10: no bits go out while the flag is raised
    p_flag_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        marker_missing |-> !out_valid);

endmodule

bind rle_bit_expander rle_bit_expander_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .in_valid       (in_valid),
    .in_last        (in_last),
    .in_ready       (in_ready),
    .out_valid      (out_valid),
    .out_bit        (out_bit),
    .out_ready      (out_ready),
    .marker_missing (marker_missing)
);

// File: tb/rle_bit_expander_tb.sv
`timescale 1ns/1ps
module rle_bit_expander_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_last = 1'b0;
    logic       in_ready;
    logic       out_valid;
    logic       out_bit;
    logic       out_ready;
    logic       marker_missing;

    always #2 clk = ~clk;

    rle_bit_expander u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .in_valid       (in_valid),
        .in_data        (in_data),
        .in_last        (in_last),
        .in_ready       (in_ready),
        .out_valid      (out_valid),
        .out_bit        (out_bit),
        .out_ready      (out_ready),
        .marker_missing (marker_missing)
    );

    int          n_chk = 0;
    int          n_fail = 0;
    int          viol = 0;
    int          bp_mode = 0;
    int          cyc = 0;
    logic [15:0] lfsr = 16'hACE1;
    bit          exp_q[$];
    bit          got_q[$];

    // Decide out_ready for the coming edge, then record the transfer it makes.
    always @(negedge clk) begin
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        case (bp_mode)
            0:       out_ready = 1'b1;
            1:       out_ready = lfsr[0];
            default: out_ready = 1'b0;
        endcase
        if (rst_n && out_valid && out_ready) got_q.push_back(out_bit);
        if (rst_n && in_ready && out_valid) viol++;
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected below 190000", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic push_prefix();
        logic [15:0] p = 16'hFF20;
        for (int i = 15; i >= 0; i--) exp_q.push_back(p[i]);
    endtask

    task automatic push_code(int c);
        if (c >= 1 && c <= 226) begin
            repeat (c) exp_q.push_back(1'b1);
            exp_q.push_back(1'b0);
        end else if (c == 227) begin
            repeat (226) exp_q.push_back(1'b1);
        end else if (c >= 228 && c <= 254) begin
            repeat (c - 228) exp_q.push_back(1'b0);
            exp_q.push_back(1'b1);
        end else if (c == 255) begin
            exp_q.push_back(1'b1);
        end
    endtask

    function automatic string req_of(int c);
        if (c == 0 || c == 255) return "R7";
        if (c <= 226) return "R4";
        if (c == 227) return "R5";
        return "R6";
    endfunction

    task automatic send(logic [7:0] b, logic last);
        in_valid = 1'b1;
        in_data  = b;
        in_last  = last;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
        while (out_valid) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic compare(string req, string what);
        int bad = -1;
        chk(got_q.size() == exp_q.size(), req, {what, " bit count"}, got_q.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < got_q.size(); i++) begin
            if (bad < 0 && got_q[i] != exp_q[i]) bad = i;
        end
        chk(bad < 0, req, {what, " first mismatching bit index"}, bad, -1);
        exp_q.delete();
        got_q.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        chk(in_ready == 1'b1 && out_valid == 1'b0 && marker_missing == 1'b0,
            "R1", "reset in_ready/out_valid/flag", {in_ready, out_valid, marker_missing}, 3'b100);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b1 && out_valid == 1'b0 && marker_missing == 1'b0,
            "R1", "after reset in_ready/out_valid/flag", {in_ready, out_valid, marker_missing}, 3'b100);

        // R2: header junk, lone 0x30, repeated 0xFF before the marker tail
        send(8'h12, 0); send(8'h30, 0); send(8'hFF, 0); send(8'h55, 0);
        send(8'hFF, 0); send(8'hFF, 0); send(8'h3A, 0);
        send(8'd3, 0); send(8'd255, 0); send(8'd230, 1);
        push_prefix(); push_code(3); push_code(255); push_code(230);
        settle();
        compare("R2", "marker after header bytes");

        // R3: marker ending the stream gives the prefix alone
        send(8'hFF, 0); send(8'h3F, 1);
        push_prefix();
        settle();
        compare("R3", "prefix-only stream");

        // R9: hold the shifter off during the prefix
        bp_mode = 2;
        send(8'hFF, 0); send(8'h30, 1);
        repeat (2) @(negedge clk);
        for (int k = 0; k < 6; k++) begin
            chk(out_valid == 1'b1 && out_bit == 1'b1, "R9", "stalled prefix bit", {out_valid, out_bit}, 2'b11);
            @(negedge clk);
        end
        bp_mode = 0;
        push_prefix();
        settle();
        compare("R9", "prefix after stall");

        // R10: stream ends without a marker
        send(8'h11, 0); send(8'hFF, 1);
        settle();
        chk(marker_missing == 1'b1, "R10", "flag after markerless stream", marker_missing, 1);
        chk(got_q.size() == 0, "R10", "bits from markerless stream", got_q.size(), 0);
        got_q.delete();
        send(8'hFF, 0); send(8'h31, 0); send(8'd5, 1);
        push_prefix(); push_code(5);
        settle();
        chk(marker_missing == 1'b0, "R10", "flag after next marker", marker_missing, 0);
        compare("R10", "stream after cleared flag");

        // R11: bytes after a closing code are searched, not expanded
        send(8'hFF, 0); send(8'h30, 0); send(8'd1, 1);
        send(8'd5, 0); send(8'hFF, 0); send(8'h3F, 0); send(8'd4, 1);
        push_prefix(); push_code(1); push_prefix(); push_code(4);
        settle();
        compare("R11", "two streams separated by header byte");

        // R4..R7 sweep: every code value alone in its own stream, random backpressure
        bp_mode = 1;
        for (int c = 0; c < 256; c++) begin
            send(8'hFF, 0); send(8'h30, 0); send(8'(c), 1);
            push_prefix(); push_code(c);
            settle();
            compare(req_of(c), $sformatf("code %0d", c));
        end

        // Back-to-back codes in one stream under backpressure (R4 R6 R7 R5)
        send(8'hFF, 0); send(8'h35, 0);
        send(8'd226, 0); send(8'd0, 0); send(8'd228, 0); send(8'd254, 0);
        send(8'd227, 0); send(8'd255, 0); send(8'd1, 1);
        push_prefix(); push_code(226); push_code(0); push_code(228); push_code(254);
        push_code(227); push_code(255); push_code(1);
        settle();
        compare("R4", "mixed code stream");
        bp_mode = 0;

        // R8: never ready for input while a bit is pending
        chk(viol == 0, "R8", "cycles with in_ready and out_valid both high", viol, 0);

        summary();
        $finish;
    end

endmodule